// File: doc/BRIEF.md
# Snooping Shared Memory Responder

This block is the central memory that sits on a shared broadcast bus between several caches, all working on one cache line reduced to a single bit. It watches a read strobe, a write strobe, an ownership claim raised by whichever cache holds a dirty copy, and the shared data line. The data line is modelled as a wired-OR. Each cache has its own drive enable, and the memory has one more. The memory keeps the line bit in a register whose set and clear requests take effect at the next clock edge.

The controller has two states. `ST_IDLE` accepts a bus command. `ST_RESOLVE` is the second cycle of a read.
- The transition idle→idle happens on no strobe or on a write. A write copies the level of the data line into the register.
- The transition idle→resolve happens on a read.
- The transition resolve→idle always happens after one cycle. In that resolve cycle, if a cache claims ownership, the memory stays off the line and records the value that cache drives. This is a write-back that cleans the owner. If no cache claims ownership, the memory drives its stored bit.

Every read therefore finishes in two cycles, whichever agent supplies the data.

Top module: `snoop_mem_resp`

## Requirements
- R1: After reset the memory does not drive the data line and the stored bit is 0, so a read with no owner returns 0.
- R2: In every cycle, `bus_data` equals the OR of all `cache_drv` bits and `mem_drv`.
- R3: A write strobe in `ST_IDLE` sets the stored bit if `bus_data` is 1 and clears it if `bus_data` is 0. Read and write strobes are never asserted together.
- R4: In the cycle of a read strobe the memory does not drive. In the following (resolve) cycle with `owner_claim` low, `mem_drv` equals the stored bit, so 1 is shown by driving and 0 by not driving.
- R5: In the resolve cycle with `owner_claim` high, `mem_drv` is 0 and the stored bit takes the value of `bus_data`.
- R6: Read or write strobes asserted during the resolve cycle are ignored: the stored bit is unchanged and no new read is started.
- R7: The resolve cycle lasts exactly one cycle, so `mem_drv` is 0 in the cycle after it and a new command is accepted there.
- R8: A register update is visible at the next clock edge, so a read issued in the cycle right after a write returns the written value.
- R9: `owner_claim` and cache drives outside a resolve cycle have no effect on the stored bit unless a write strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| owner_claim | input | 1 | Some cache asserts ownership of the dirty line |
| cache_drv | input | NUM_CACHES | Per-cache drive enables for the data line |
| mem_drv | output | 1 | Memory's own drive enable for the data line |
| bus_data | output | 1 | Resolved wired-OR data line |

## Verification
The two functions that can fall in the same cycle are the resolve step of a read and a fresh strobe that a misbehaving master raises in that same cycle. The bench provokes this by raising a write strobe, with a cache driving 1, during the resolve cycle, and separately by raising a read strobe there. It judges the outcome by reading the line back afterwards and by checking that the memory stays silent in the following cycle. A second overlap, write-back capture alongside the memory's own drive decision, is judged by sweeping the stored bit, the owner claim and the owner's value exhaustively.

// File: rtl/snoop_mem_pkg.sv
package snoop_mem_pkg;
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_RESOLVE = 1'b1
    } rsp_state_t;
endpackage

// File: rtl/line_bit_reg.sv
module line_bit_reg #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= RST_VAL;
        else if (clr_i) q_o <= 1'b0;   // clear beats set
        else if (set_i) q_o <= 1'b1;
    end

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !q_o);                                   // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(q_o));              // R9
endmodule

// File: rtl/wired_or_line.sv
module wired_or_line #(
    parameter int unsigned N_DRV = 3
) (
    input  logic [N_DRV-1:0] drv_i,
    output logic             line_o
);
    logic [N_DRV:0] chain;
    assign chain[0] = 1'b0;
    for (genvar g = 0; g < N_DRV; g++) begin : g_or
        assign chain[g+1] = chain[g] | drv_i[g];
    end
    assign line_o = chain[N_DRV];
endmodule

// File: rtl/rsp_fsm.sv
module rsp_fsm
    import snoop_mem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rd,
    input  logic bus_wr,
    input  logic owner_claim,
    input  logic bus_data,
    input  logic line_val,
    output logic mem_drv,
    output logic set_o,
    output logic clr_o
);
    rsp_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and bus drive
    always_comb begin
        state_d = state_q;
        mem_drv = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_rd) state_d = ST_RESOLVE;
            end
            ST_RESOLVE: begin
                state_d = ST_IDLE;
                if (!owner_claim) mem_drv = line_val;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // register capture requests
    always_comb begin
        set_o = 1'b0;
        clr_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_wr) begin
                    set_o = bus_data;
                    clr_o = !bus_data;
                end
            end
            ST_RESOLVE: begin
                if (owner_claim) begin
                    set_o = bus_data;
                    clr_o = !bus_data;
                end
            end
            default: ;
        endcase
    end

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));                                          // R3
    AST_WR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && bus_wr) |=> (line_val == $past(bus_data))); // R3
    AST_DRV_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_drv |-> ($past(bus_rd) && !owner_claim));                  // R4
    AST_OWNER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESOLVE && owner_claim) |=> (line_val == $past(bus_data))); // R5
    AST_RESOLVE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESOLVE && !owner_claim) |=> $stable(line_val)); // R6
    AST_RESOLVE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESOLVE) |=> (state_q == ST_IDLE));             // R7
endmodule

// File: rtl/snoop_mem_resp.sv
module snoop_mem_resp #(
    parameter int unsigned NUM_CACHES = 2,
    parameter logic        LINE_RST   = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic                  owner_claim,
    input  logic [NUM_CACHES-1:0] cache_drv,
    output logic                  mem_drv,
    output logic                  bus_data
);
    localparam int unsigned N_DRV = NUM_CACHES + 1;

    logic line_q;
    logic set_req;
    logic clr_req;
    logic [N_DRV-1:0] drv_vec;

    assign drv_vec = {cache_drv, mem_drv};

    wired_or_line #(.N_DRV(N_DRV)) u_line (
        .drv_i  (drv_vec),
        .line_o (bus_data)
    );

    rsp_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .owner_claim (owner_claim),
        .bus_data    (bus_data),
        .line_val    (line_q),
        .mem_drv     (mem_drv),
        .set_o       (set_req),
        .clr_o       (clr_req)
    );

    line_bit_reg #(.RST_VAL(LINE_RST)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_req),
        .clr_i (clr_req),
        .q_o   (line_q)
    );

    AST_OWNER_SILENCES_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        owner_claim |-> !mem_drv);                                     // R5
endmodule

// File: tb/snoop_mem_resp_bench.sv
`timescale 1ns/1ps
module snoop_mem_resp_bench;
    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic          owner_claim = 1'b0;
    logic [NC-1:0] cache_drv = '0;
    logic          mem_drv;
    logic          bus_data;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_line = 1'b0;

    always #10 clk = ~clk;

    snoop_mem_resp #(.NUM_CACHES(NC)) u_snoop_mem_resp (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .owner_claim(owner_claim), .cache_drv(cache_drv),
        .mem_drv(mem_drv), .bus_data(bus_data)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic set_in(input logic rd, input logic wr, input logic own, input logic [NC-1:0] cd);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; owner_claim = own; cache_drv = cd;
        #2;
        check("R2 wired-or", bus_data, (|cd) | mem_drv);
    endtask

    task automatic idle_cycle();
        set_in(1'b0, 1'b0, 1'b0, '0);
        check("R7 idle no drive", mem_drv, 1'b0);
    endtask

    task automatic do_write(input logic v);
        set_in(1'b0, 1'b1, 1'b0, v ? 2'b01 : 2'b00);
        check("R3 write data", bus_data, v);
        exp_line = v;
    endtask

    // odd: 0 none, 1 write 1 in resolve, 2 read in resolve
    task automatic do_read(input logic own, input logic ov, input int odd);
        logic [NC-1:0] cd;
        set_in(1'b1, 1'b0, 1'b0, '0);
        check("R4 no drive in request cycle", mem_drv, 1'b0);
        cd = (own && ov) ? 2'b10 : 2'b00;
        if (odd == 1) cd = cd | 2'b01;
        set_in(odd == 2, odd == 1, own, cd);
        if (own) begin
            check("R5 memory silent on owner", mem_drv, 1'b0);
            check("R5 owner data", bus_data, ov | (odd == 1));
            exp_line = ov | (odd == 1);
        end else begin
            check("R4 drive stored bit", mem_drv, exp_line);
        end
        set_in(1'b0, 1'b0, 1'b0, '0);
        check("R7 resolve lasts one cycle", mem_drv, 1'b0);
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check("R1 no drive in reset", mem_drv, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R1 no drive after reset", mem_drv, 1'b0);
        do_read(1'b0, 1'b0, 0);                 // R1 stored bit 0
        // R2 sweep of cache drives in idle
        for (int c = 0; c < 4; c++) set_in(1'b0, 1'b0, 1'b0, c[NC-1:0]);
        // exhaustive sweep: stored bit x owner claim x owner value
        for (int p = 0; p < 2; p++)
            for (int o = 0; o < 2; o++)
                for (int v = 0; v < 2; v++) begin
                    do_write(p[0]);
                    idle_cycle();
                    do_read(o[0], v[0], 0);      // R4 / R5
                    do_read(1'b0, 1'b0, 0);      // R5 write-back visible
                end
        // R8 back-to-back write then read
        for (int p = 0; p < 2; p++) begin
            do_write(p[0]);
            do_read(1'b0, 1'b0, 0);
        end
        // R6 write strobe in resolve cycle ignored
        do_write(1'b0);
        do_read(1'b0, 1'b0, 1);
        do_read(1'b0, 1'b0, 0);
        // R6 read strobe in resolve cycle starts nothing
        do_write(1'b1);
        do_read(1'b0, 1'b0, 2);
        check("R6 no second resolve", mem_drv, 1'b0);
        do_read(1'b0, 1'b0, 0);
        // R9 owner claim and drives while idle
        do_write(1'b0);
        set_in(1'b0, 1'b0, 1'b1, 2'b11);
        set_in(1'b0, 1'b0, 1'b1, 2'b01);
        idle_cycle();
        do_read(1'b0, 1'b0, 0);                 // R9 still 0
        check("R9 stored bit kept", exp_line, 1'b0);
        idle_cycle();
        finish_run();
    end
endmodule